// File: doc/BRIEF.md
# GF(2^571) Single-Cycle Modular Multiplier

This block multiplies two elements of the binary field GF(2^571) and returns the product already reduced by the field polynomial. Each result takes one clock, and a new operand pair can be taken on every clock. The carry-less product is built by a recursive Karatsuba split. The split stops at a small base width, where a plain shift-and-AND array takes over. A fused fold then brings the 1141-bit raw product back down to 571 bits.

Squaring needs no separate unit. When the square strobe qualifier is set, the same datapath is used with the first operand routed to both multiplier inputs, and the second operand port is ignored.

A two-state output tracker drives the valid flag. State `ST_EMPTY` means no fresh result is held, and `ST_FULL` means the result register holds a product that was captured on the last edge. The transition `EMPTY->FULL` or `FULL->FULL` is taken on any edge where the strobe is high. The transition `FULL->EMPTY` or `EMPTY->EMPTY` is taken on any edge where the strobe is low.

Top module: `gf_mul_top`

## Requirements
- R1: While reset is asserted (active low), `out_valid` is 0 and `result` is all zeros.
- R2: `out_valid` is 1 in exactly the cycle that follows a cycle with `in_valid` high. It is 0 after a cycle with `in_valid` low.
- R3: With `sq_mode` = 0, the result for a strobed pair is op_a·op_b mod (x^571 + x^10 + x^5 + x^2 + 1). Bit i of each vector is the coefficient of x^i. A zero operand gives zero, and an all-ones operand is reduced correctly.
- R4: On a cycle with `in_valid` low, `result` keeps its previous value, whatever the operand inputs do.
- R5: Operand pairs strobed on consecutive cycles each produce their own correct result, one per cycle, with no gap.
- R6: With `sq_mode` = 1, the result is op_a² mod the field polynomial, and `op_b` has no effect.
- R7: Multiplying by the constant 1 returns op_a unchanged. The product x^570·x wraps to x^10 + x^5 + x^2 + 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands present this cycle |
| sq_mode | input | 1 | 1 = square op_a, ignore op_b |
| op_a | input | 571 | First field element |
| op_b | input | 571 | Second field element |
| out_valid | output | 1 | Result register holds a fresh product |
| result | output | 571 | Reduced product |

## Verification
A wrong tracker state shows at the port on the very next edge: `out_valid` either lags or lingers by a cycle. A fault in the Karatsuba recombination or in the reduction fold cannot hide. It corrupts `result` in the one cycle after the strobe, and that cycle is compared against a bit-serial interleaved reference. The corner operands zero, one, all-ones and the top-bit wrap each target one stage. The wrap exposes a wrong reduction tap, the identity exposes a wrong split, and the all-ones operand exposes a wrong middle-term fold.

// File: rtl/gf_pkg.sv
package gf_pkg;
    // Field size and reduction taps of x^571 + x^10 + x^5 + x^2 + 1
    localparam int FIELD_W   = 571;
    localparam int TAP_HI    = 10;
    localparam int TAP_MID   = 5;
    localparam int TAP_LO    = 2;
    // Width at which the Karatsuba recursion falls back to an AND array
    localparam int KARA_BASE = 32;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } out_state_e;
endpackage

// File: rtl/gf_karatsuba.sv
// Recursive carry-less multiplier: W x W -> 2W-1 bits.
module gf_karatsuba #(
    parameter int W    = 571,
    parameter int BASE = 32
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-2:0] p
);
    generate
        if (W <= BASE) begin : g_leaf
            always_comb begin
                p = '0;
                for (int i = 0; i < W; i++) begin
                    for (int j = 0; j < W; j++) begin
                        p[i+j] = p[i+j] ^ (a[i] & b[j]);
                    end
                end
            end
        end else begin : g_split
            localparam int LW = (W + 1) / 2;   // low half (larger)
            localparam int HW = W - LW;        // high half
            logic [LW-1:0]     a_lo, b_lo, a_sum, b_sum;
            logic [HW-1:0]     a_hi, b_hi;
            logic [2*LW-2:0]   p_lo, p_mid, mid;
            logic [2*HW-2:0]   p_hi;

            assign a_lo = a[LW-1:0];
            assign b_lo = b[LW-1:0];
            assign a_hi = a[W-1:LW];
            assign b_hi = b[W-1:LW];

            // High half zero-padded to the low-half width for the middle term
            always_comb begin
                a_sum = a_lo;
                b_sum = b_lo;
                a_sum[HW-1:0] = a_lo[HW-1:0] ^ a_hi;
                b_sum[HW-1:0] = b_lo[HW-1:0] ^ b_hi;
            end

            gf_karatsuba #(.W(LW), .BASE(BASE)) u_lo  (.a(a_lo),  .b(b_lo),  .p(p_lo));
            gf_karatsuba #(.W(HW), .BASE(BASE)) u_hi  (.a(a_hi),  .b(b_hi),  .p(p_hi));
            gf_karatsuba #(.W(LW), .BASE(BASE)) u_mid (.a(a_sum), .b(b_sum), .p(p_mid));

            always_comb begin
                mid = p_mid ^ p_lo;
                mid[2*HW-2:0] = mid[2*HW-2:0] ^ p_hi;
                p = '0;
                p[2*LW-2:0]    = p[2*LW-2:0] ^ p_lo;
                p[LW +: 2*LW-1] = p[LW +: 2*LW-1] ^ mid;
                p[2*W-2:2*LW]  = p[2*W-2:2*LW] ^ p_hi;
            end
        end
    endgenerate
endmodule

// File: rtl/gf_reduce.sv
// Folds a (2M-1)-bit carry-less product modulo x^M + x^T1 + x^T2 + x^T3 + 1.
module gf_reduce #(
    parameter int M  = 571,
    parameter int T1 = 10,
    parameter int T2 = 5,
    parameter int T3 = 2
) (
    input  logic [2*M-2:0] raw,
    output logic [M-1:0]   red
);
    logic [2*M-2:0] work;

    // Descending fold: every tap lands below the bit being cleared,
    // so bits pushed above M-1 are folded again later in the loop.
    always_comb begin
        work = raw;
        for (int i = 2*M-2; i >= M; i--) begin
            if (work[i]) begin
                work[i-M]      = ~work[i-M];
                work[i-M+T3]   = ~work[i-M+T3];
                work[i-M+T2]   = ~work[i-M+T2];
                work[i-M+T1]   = ~work[i-M+T1];
            end
        end
        red = work[M-1:0];
    end
endmodule

// File: rtl/gf_mul_top.sv
module gf_mul_top
    import gf_pkg::*;
#(
    parameter int M    = gf_pkg::FIELD_W,
    parameter int BASE = gf_pkg::KARA_BASE
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic         sq_mode,
    input  logic [M-1:0] op_a,
    input  logic [M-1:0] op_b,
    output logic         out_valid,
    output logic [M-1:0] result
);
    out_state_e     state_q, state_d;
    logic [M-1:0]   b_sel;
    logic [2*M-2:0] raw_prod;
    logic [M-1:0]   reduced;
    logic [M-1:0]   result_q;

    // Squaring shares the multiplier: first operand feeds both inputs
    assign b_sel = sq_mode ? op_a : op_b;

    gf_karatsuba #(.W(M), .BASE(BASE)) u_kara (
        .a(op_a),
        .b(b_sel),
        .p(raw_prod)
    );

    gf_reduce #(.M(M), .T1(TAP_HI), .T2(TAP_MID), .T3(TAP_LO)) u_red (
        .raw(raw_prod),
        .red(reduced)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: state_d = in_valid ? ST_FULL : ST_EMPTY;
            ST_FULL:  state_d = in_valid ? ST_FULL : ST_EMPTY;
            default:  state_d = ST_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // Result register, loaded only on a strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        result_q <= '0;
        else if (in_valid) result_q <= reduced;
    end

    // Outputs
    always_comb begin
        out_valid = (state_q == ST_FULL);
        result    = result_q;
    end
endmodule

// File: rtl/gf_mul_chk.sv
module gf_mul_chk #(
    parameter int M = 571
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic         sq_mode,
    input logic [M-1:0] op_a,
    input logic [M-1:0] op_b,
    input logic         out_valid,
    input logic [M-1:0] result
);
    p_valid_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_valid_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));

    p_zero_op_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op_a == '0 || (!sq_mode && op_b == '0))) |=> (result == '0));

    p_identity_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !sq_mode && op_b == M'(1)) |=> (result == $past(op_a)));
endmodule

bind gf_mul_top gf_mul_chk #(.M(M)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sq_mode(sq_mode),
    .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .result(result)
);

// File: tb/test_gf_mul_top.sv
module test_gf_mul_top;
    localparam int M = 571;
    localparam logic [M-1:0] POLY_LOW = M'(11'h425); // x^10+x^5+x^2+1

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         sq_mode = 1'b0;
    logic [M-1:0] op_a = '0;
    logic [M-1:0] op_b = '0;
    logic         out_valid;
    logic [M-1:0] result;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    gf_mul_top i_gf_mul_top (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sq_mode(sq_mode),
        .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .result(result)
    );

    // {sq_mode, seed_a, seed_b}
    localparam int NV = 8;
    localparam logic [64:0] VEC [NV] = '{
        {1'b0, 32'h0000_0001, 32'h0000_0002},
        {1'b0, 32'hDEAD_BEEF, 32'h1234_5678},
        {1'b1, 32'hCAFE_F00D, 32'h0BAD_0BAD},
        {1'b0, 32'h8000_0000, 32'h7FFF_FFFF},
        {1'b0, 32'hA5A5_A5A5, 32'h5A5A_5A5A},
        {1'b1, 32'h0F0F_0F0F, 32'hFFFF_0000},
        {1'b0, 32'h1357_9BDF, 32'h2468_ACE0},
        {1'b0, 32'hFEED_FACE, 32'hC0FF_EE00}
    };

    function automatic logic [M-1:0] expand(input logic [31:0] s);
        logic [575:0] acc;
        logic [31:0]  x;
        x = s ^ 32'h9E37_79B9;
        if (x == 0) x = 32'h1;
        for (int i = 0; i < 18; i++) begin
            x = x ^ (x << 13);
            x = x ^ (x >> 17);
            x = x ^ (x << 5);
            acc[i*32 +: 32] = x;
        end
        return acc[M-1:0];
    endfunction

    // Bit-serial multiply with reduction interleaved, MSB of b first
    function automatic logic [M-1:0] ref_mul(input logic [M-1:0] a, input logic [M-1:0] b);
        logic [M-1:0] r;
        logic         top;
        r = '0;
        for (int i = M-1; i >= 0; i--) begin
            top = r[M-1];
            r = {r[M-2:0], 1'b0};
            if (top) r = r ^ POLY_LOW;
            if (b[i]) r = r ^ a;
        end
        return r;
    endfunction

    task automatic check_bit(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic check_vec(input string tag, input logic [M-1:0] act, input logic [M-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Strobe one pair, check it one cycle later, then deassert the strobe
    task automatic one_op(input string tag, input logic sq, input logic [M-1:0] a,
                          input logic [M-1:0] b, input logic [M-1:0] exp);
        in_valid = 1'b1; sq_mode = sq; op_a = a; op_b = b;
        @(negedge clk);
        check_bit({tag, " valid"}, out_valid, 1'b1);
        check_vec(tag, result, exp);
        in_valid = 1'b0; sq_mode = 1'b0;
    endtask

    initial begin
        logic [M-1:0] exp_last;
        logic [M-1:0] ra;
        logic [M-1:0] ones;
        logic [M-1:0] wrap;
        ones = '1;
        exp_last = '0;

        // R1: reset state
        repeat (3) @(negedge clk);
        check_bit("R1 out_valid in reset", out_valid, 1'b0);
        check_vec("R1 result in reset", result, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check_bit("R2 idle after reset", out_valid, 1'b0);

        // R3, R5, R6: table walked back-to-back, one pair per cycle
        for (int k = 0; k < NV; k++) begin
            logic [M-1:0] va, vb;
            va = expand(VEC[k][63:32]);
            vb = expand(VEC[k][31:0]);
            in_valid = 1'b1;
            sq_mode  = VEC[k][64];
            op_a     = va;
            op_b     = vb;
            exp_last = ref_mul(va, VEC[k][64] ? va : vb);
            @(negedge clk);
            check_bit("R5 back-to-back valid", out_valid, 1'b1);
            check_vec(VEC[k][64] ? "R6 table square" : "R3 table product", result, exp_last);
        end

        // R2, R4: strobe dropped while operands keep changing
        in_valid = 1'b0;
        op_a = expand(32'h5555_1111);
        op_b = expand(32'h2222_3333);
        @(negedge clk);
        check_bit("R2 valid drops", out_valid, 1'b0);
        check_vec("R4 result held", result, exp_last);
        op_a = ones;
        @(negedge clk);
        check_vec("R4 result still held", result, exp_last);

        ra = expand(32'h0ACE_1234);

        // R3 corner cases
        one_op("R3 zero operand", 1'b0, ra, '0, '0);
        one_op("R3 all-ones product", 1'b0, ones, ones, ref_mul(ones, ones));
        one_op("R3 all-ones times random", 1'b0, ones, ra, ref_mul(ones, ra));

        // R7: identity and top-bit wrap
        one_op("R7 times one", 1'b0, ra, M'(1), ra);
        wrap = '0;
        wrap[M-1] = 1'b1;
        one_op("R7 x^570 times x", 1'b0, wrap, M'(2), POLY_LOW);

        // R6: squaring ignores op_b
        one_op("R6 square random b", 1'b1, ra, ones, ref_mul(ra, ra));
        one_op("R6 square all-ones", 1'b1, ones, '0, ref_mul(ones, ones));
        one_op("R6 square of x^570", 1'b1, wrap, expand(32'h77), ref_mul(wrap, wrap));

        @(negedge clk);
        check_bit("R2 idle at end", out_valid, 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule